// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash device whose storage is a uniform-sector array in on-chip registers. It sits on a simple synchronous bus with a word address, 16-bit write data, a write strobe, a read strobe, 16-bit read data and a one-cycle ready response. Bus writes do not go straight into the array. A write-cycle state machine decodes them as commands: the low byte of the first write picks an operation, and the writes that follow carry a confirm code, a word count or data.

Reads are steered by the command currently latched. With no command latched they return array words. Status-type commands return the status byte. The identifier command returns the manufacturer or device code. Query mode returns entries from a parameter-computed table. A read-only strap turns every program and erase into a reported error and leaves the array untouched. Program and erase finish in the cycle they are confirmed, so no busy period is modelled.

Top module: `pnor_cmd_engine`

## Requirements
- R1: After reset no command is latched, the status byte is 0x00, `rdy` is low, and every array word reads 0xFFFF.
- R2: Every bus access (`rd_en` or `wr_en` high for one cycle) is answered by `rdy` high in exactly the following cycle, and `rdy` is low in any cycle that follows a cycle with no access. Read data is valid while `rdy` is high.
- R3: A first write with low byte 0x40 or 0x10, followed by a second write, stores the second write's 16-bit data at the second write's word address and sets status bit 7 (0x80, ready). Afterwards reads return array words.
- R4: When `ro_strap` is high, the program sequence of R3 leaves the array unchanged and sets status bit 4 (0x10) as well as bit 7.
- R5: A write of 0x20 followed by a write of 0xD0 sets every word of the sector holding the first write's address to 0xFFFF and leaves the other sectors alone. With `ro_strap` high the array is unchanged and status bit 5 (0x20) is set. Bit 7 is set in both cases.
- R6: A write of 0x20 followed by a write of 0xFF aborts: the array is unchanged and reads return array words.
- R7: While the latched command is 0x20, 0x60, 0x70 or 0xE8, every read returns {0x00, status}.
- R8: A first write of 0x50 clears the whole status byte and returns to array reads.
- R9: After a write of 0x90, a read at word offset 0 (low seven address bits) returns `ID_MFR`, offset 1 returns `ID_DEV`, and any other offset returns 0.
- R10: After a write of 0x98, a read at offset k returns {0x00, table[k]}, with 0x51 ('Q') at offset 0x10, 0x52 ('R') at 0x11 and `NUM_SECT`-1 at 0x2D. Any offset above 0x51 returns 0. Writes other than 0xFF keep query mode, and 0xFF leaves it.
- R11: A write of 0xE8, then a count N, then N+1 data writes, stores each data word at its address. A following 0xD0 confirm returns to idle with the status byte still latched for reads.
- R12: A first-cycle low byte outside the command set (0x00, 0x10, 0x20, 0x40, 0x50, 0x60, 0x70, 0x90, 0x98, 0xE8, 0xFF) clears the latched command, so the next read returns an array word.
- R13: A write of 0x60 followed by 0xD0 or 0x01 sets status bit 7 and keeps status reads. Any other second write returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data; the low byte is the command code |
| rd_en | input | 1 | Read strobe, one cycle per read |
| ro_strap | input | 1 | High makes the device read-only |
| rd_data | output | 16 | Read data, valid while rdy is high |
| rdy | output | 1 | One-cycle response to each access |

## Verification
The bench targets these corner cases:
- An erase must clear exactly one sector. A wrong sector mask would blank a neighbouring word that was programmed earlier.
- An erase aborted with 0xFF must change nothing, so a design that erases at setup would lose data.
- The buffered write must store count-plus-one words. An off-by-one in the count would leave the last word blank or write past it.
- With the read-only strap set, the design must report status bits 4 or 5 and keep the array intact; a design that ignores the strap would overwrite it.
- Query offsets past the table end must read zero.
- Unknown first-cycle codes must drop back to array reads instead of leaving a stale status mode latched.

// File: rtl/pnor_pkg.sv
package pnor_pkg;

    typedef enum logic [1:0] {
        WC_IDLE = 2'd0,
        WC_ARG  = 2'd1,
        WC_DATA = 2'd2,
        WC_CONF = 2'd3
    } wc_e;

    localparam logic [7:0] OP_NULL    = 8'h00;
    localparam logic [7:0] OP_UNLOCK  = 8'h01;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLRST   = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_RDST    = 8'h70;
    localparam logic [7:0] OP_RDID    = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;

    localparam int ST_READY   = 7;
    localparam int ST_ERS_ERR = 5;
    localparam int ST_PRG_ERR = 4;

    localparam logic [6:0] QRY_LAST = 7'h51;

    typedef struct packed {
        wc_e        wc;
        logic [7:0] cmd;
        logic [7:0] status;
    } ctl_t;

    function automatic logic [7:0] qry_entry(input logic [6:0] off,
                                             input int unsigned nsect,
                                             input int unsigned sect_bytes,
                                             input int unsigned size_lg);
        logic [7:0] v;
        case (off)
            7'h10: v = 8'h51;
            7'h11: v = 8'h52;
            7'h12: v = 8'h59;
            7'h13: v = 8'h01;
            7'h15: v = 8'h31;
            7'h1B: v = 8'h45;
            7'h1C: v = 8'h55;
            7'h1F: v = 8'h07;
            7'h20: v = 8'h07;
            7'h21: v = 8'h0A;
            7'h23: v = 8'h04;
            7'h24: v = 8'h04;
            7'h25: v = 8'h04;
            7'h27: v = 8'(size_lg);
            7'h28: v = 8'h01;
            7'h2A: v = 8'h05;
            7'h2C: v = 8'h01;
            7'h2D: v = 8'(nsect - 1);
            7'h2E: v = 8'((nsect - 1) >> 8);
            7'h2F: v = 8'(sect_bytes >> 8);
            7'h30: v = 8'(sect_bytes >> 16);
            7'h31: v = 8'h50;
            7'h32: v = 8'h52;
            7'h33: v = 8'h49;
            7'h34: v = 8'h31;
            7'h35: v = 8'h30;
            7'h3F: v = 8'h01;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic is_status_cmd(input logic [7:0] c);
        return (c == OP_ERASE) || (c == OP_CLRST) || (c == OP_LOCK) ||
               (c == OP_RDST)  || (c == OP_BUFWR);
    endfunction

endpackage

// File: rtl/pnor_wr_fsm.sv
module pnor_wr_fsm
    import pnor_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int WORD_LG = 4,
    parameter int CNT_W   = 8,
    localparam int SECT_W = IDX_W - WORD_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [15:0]       wr_data,
    input  logic              ro,
    output ctl_t              ctl,
    output logic              prg_en,
    output logic              ers_en,
    output logic [SECT_W-1:0] ers_sect
);
    ctl_t              cur, nxt;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [SECT_W-1:0] sect_q, sect_n;
    logic              to_array;
    logic [7:0]        code;

    assign code     = wr_data[7:0];
    assign ctl      = cur;
    assign ers_sect = sect_q;

    always_comb begin
        nxt      = cur;
        cnt_n    = cnt_q;
        sect_n   = sect_q;
        prg_en   = 1'b0;
        ers_en   = 1'b0;
        to_array = 1'b0;
        if (wr_en) begin
            unique case (cur.wc)
                WC_IDLE: begin
                    case (code)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            nxt.wc  = WC_ARG;
                            nxt.cmd = code;
                        end
                        OP_ERASE: begin
                            nxt.wc  = WC_ARG;
                            nxt.cmd = code;
                            nxt.status[ST_READY] = 1'b1;
                            sect_n  = wr_idx[IDX_W-1:WORD_LG];
                        end
                        OP_BUFWR: begin
                            nxt.wc  = WC_ARG;
                            nxt.cmd = code;
                            nxt.status[ST_READY] = 1'b1;
                        end
                        OP_RDST, OP_RDID: nxt.cmd = code;
                        OP_CLRST: begin
                            nxt.status = 8'h00;
                            to_array   = 1'b1;
                        end
                        default: to_array = 1'b1;
                    endcase
                end
                WC_ARG: begin
                    case (cur.cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            if (ro) nxt.status[ST_PRG_ERR] = 1'b1;
                            else    prg_en = 1'b1;
                            nxt.status[ST_READY] = 1'b1;
                            nxt.wc = WC_IDLE;
                        end
                        OP_ERASE: begin
                            if (code == OP_CONFIRM) begin
                                if (ro) nxt.status[ST_ERS_ERR] = 1'b1;
                                else    ers_en = 1'b1;
                                nxt.status[ST_READY] = 1'b1;
                                nxt.wc = WC_IDLE;
                            end else begin
                                to_array = 1'b1;
                            end
                        end
                        OP_LOCK: begin
                            if (code == OP_CONFIRM || code == OP_UNLOCK) begin
                                nxt.status[ST_READY] = 1'b1;
                                nxt.wc = WC_IDLE;
                            end else begin
                                to_array = 1'b1;
                            end
                        end
                        OP_QUERY: to_array = (code == OP_ARRAY);
                        OP_BUFWR: begin
                            cnt_n  = wr_data[CNT_W-1:0];
                            nxt.wc = WC_DATA;
                        end
                        default: to_array = 1'b1;
                    endcase
                end
                WC_DATA: begin
                    if (ro) nxt.status[ST_PRG_ERR] = 1'b1;
                    else    prg_en = 1'b1;
                    nxt.status[ST_READY] = 1'b1;
                    if (cnt_q == '0) nxt.wc = WC_CONF;
                    cnt_n = cnt_q - 1'b1;
                end
                WC_CONF: begin
                    if (code == OP_CONFIRM) begin
                        nxt.status[ST_READY] = 1'b1;
                        nxt.wc = WC_IDLE;
                    end else begin
                        to_array = 1'b1;
                    end
                end
            endcase
            if (to_array) begin
                nxt.wc  = WC_IDLE;
                nxt.cmd = OP_NULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '{wc: WC_IDLE, cmd: OP_NULL, status: 8'h00};
            cnt_q  <= '0;
            sect_q <= '0;
        end else begin
            cur    <= nxt;
            cnt_q  <= cnt_n;
            sect_q <= sect_n;
        end
    end
endmodule

// File: rtl/pnor_array.sv
module pnor_array #(
    parameter int IDX_W   = 6,
    parameter int WORD_LG = 4,
    localparam int SECT_W = IDX_W - WORD_LG,
    localparam int WORDS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prg_en,
    input  logic [IDX_W-1:0]  prg_idx,
    input  logic [15:0]       prg_data,
    input  logic              ers_en,
    input  logic [SECT_W-1:0] ers_sect,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [15:0]       rd_word
);
    logic [15:0] mem [WORDS];

    assign rd_word = mem[rd_idx];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= 16'hFFFF;
            end else if (ers_en && MY_IDX[IDX_W-1:WORD_LG] == ers_sect) begin
                mem[i] <= 16'hFFFF;
            end else if (prg_en && prg_idx == MY_IDX) begin
                mem[i] <= prg_data;
            end
        end
    end
endmodule

// File: rtl/pnor_rd_mux.sv
module pnor_rd_mux
    import pnor_pkg::*;
#(
    parameter logic [15:0] ID_MFR     = 16'h00A7,
    parameter logic [15:0] ID_DEV     = 16'h5C31,
    parameter int unsigned NSECT      = 4,
    parameter int unsigned SECT_BYTES = 32,
    parameter int unsigned SIZE_LG    = 7
) (
    input  logic [7:0]  cmd,
    input  logic [7:0]  status,
    input  logic [6:0]  off,
    input  logic [15:0] arr_word,
    output logic [15:0] data
);
    always_comb begin
        if (is_status_cmd(cmd)) begin
            data = {8'h00, status};
        end else if (cmd == OP_RDID) begin
            case (off)
                7'd0:    data = ID_MFR;
                7'd1:    data = ID_DEV;
                default: data = 16'h0000;
            endcase
        end else if (cmd == OP_QUERY) begin
            data = (off > QRY_LAST) ? 16'h0000
                 : {8'h00, qry_entry(off, NSECT, SECT_BYTES, SIZE_LG)};
        end else begin
            data = arr_word;
        end
    end
endmodule

// File: rtl/pnor_cmd_engine.sv
module pnor_cmd_engine
    import pnor_pkg::*;
#(
    parameter int          SECT_LG = 2,
    parameter int          WORD_LG = 4,
    parameter int          CNT_W   = 8,
    parameter logic [15:0] ID_MFR  = 16'h00A7,
    parameter logic [15:0] ID_DEV  = 16'h5C31,
    localparam int IDX_W  = SECT_LG + WORD_LG,
    localparam int ADDR_W = (IDX_W > 7) ? IDX_W : 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    input  logic              ro_strap,
    output logic [15:0]       rd_data,
    output logic              rdy
);
    localparam int unsigned NSECT      = 1 << SECT_LG;
    localparam int unsigned SECT_BYTES = 2 << WORD_LG;
    localparam int unsigned SIZE_LG    = IDX_W + 1;

    ctl_t               ctl;
    logic               prg_en, ers_en;
    logic [SECT_LG-1:0] ers_sect;
    logic [15:0]        arr_word, mux_data;
    logic [IDX_W-1:0]   idx;

    assign idx = addr[IDX_W-1:0];

    pnor_wr_fsm #(.IDX_W(IDX_W), .WORD_LG(WORD_LG), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data),
        .ro(ro_strap), .ctl(ctl), .prg_en(prg_en), .ers_en(ers_en),
        .ers_sect(ers_sect)
    );

    pnor_array #(.IDX_W(IDX_W), .WORD_LG(WORD_LG)) array_i (
        .clk(clk), .rst(rst), .prg_en(prg_en), .prg_idx(idx),
        .prg_data(wr_data), .ers_en(ers_en), .ers_sect(ers_sect),
        .rd_idx(idx), .rd_word(arr_word)
    );

    pnor_rd_mux #(.ID_MFR(ID_MFR), .ID_DEV(ID_DEV), .NSECT(NSECT),
                  .SECT_BYTES(SECT_BYTES), .SIZE_LG(SIZE_LG)) mux_i (
        .cmd(ctl.cmd), .status(ctl.status), .off(addr[6:0]),
        .arr_word(arr_word), .data(mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy     <= 1'b0;
            rd_data <= 16'h0000;
        end else begin
            rdy <= rd_en | wr_en;
            if (rd_en) rd_data <= mux_data;
        end
    end
endmodule

// File: rtl/pnor_cmd_engine_chk.sv
module pnor_cmd_engine_chk
    import pnor_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_code,
    input logic       ro_strap,
    input logic       rdy,
    input ctl_t       ctl,
    input logic       prg_en,
    input logic       ers_en
);
    logic known;
    assign known = (wr_code == OP_NULL)  || (wr_code == OP_PROG_A) ||
                   (wr_code == OP_ERASE) || (wr_code == OP_PROG_B) ||
                   (wr_code == OP_CLRST) || (wr_code == OP_LOCK)   ||
                   (wr_code == OP_RDST)  || (wr_code == OP_RDID)   ||
                   (wr_code == OP_QUERY) || (wr_code == OP_BUFWR)  ||
                   (wr_code == OP_ARRAY);

    AST_RDY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |=> rdy);                                       // R2
    AST_RDY_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |=> !rdy);                                     // R2
    AST_RO_NO_PROGRAM: assert property (@(posedge clk) disable iff (rst)
        ro_strap |-> !prg_en);                                           // R4
    AST_RO_NO_ERASE: assert property (@(posedge clk) disable iff (rst)
        ro_strap |-> !ers_en);                                           // R5
    AST_PROGRAM_READY: assert property (@(posedge clk) disable iff (rst)
        prg_en |=> ctl.status[ST_READY]);                                // R3
    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl.wc == WC_IDLE && wr_code == OP_CLRST)
        |=> (ctl.status == 8'h00 && ctl.cmd == OP_NULL));                // R8
    AST_UNKNOWN_CODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl.wc == WC_IDLE && !known)
        |=> (ctl.cmd == OP_NULL && ctl.wc == WC_IDLE));                  // R12
    AST_ERASE_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        ers_en |=> (ctl.wc == WC_IDLE && ctl.status[ST_READY]));         // R5
endmodule

bind pnor_cmd_engine pnor_cmd_engine_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .wr_code(wr_data[7:0]), .ro_strap(ro_strap), .rdy(rdy), .ctl(ctl),
    .prg_en(prg_en), .ers_en(ers_en)
);

// File: tb/pnor_cmd_engine_tb_top.sv
module pnor_cmd_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h5C31;

    typedef struct packed {
        logic        is_rd;
        logic [6:0]  a;
        logic [15:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h00, 16'hFFFF, 4'd1},   // R1 blank array
        '{1'b0, 7'h02, 16'h0040, 4'd3},   // R3 program setup
        '{1'b0, 7'h02, 16'h1234, 4'd3},
        '{1'b1, 7'h02, 16'h1234, 4'd3},
        '{1'b0, 7'h00, 16'h0070, 4'd7},   // R7 read status
        '{1'b1, 7'h00, 16'h0080, 4'd7},
        '{1'b0, 7'h00, 16'h0050, 4'd8},   // R8 clear status
        '{1'b1, 7'h02, 16'h1234, 4'd8},
        '{1'b0, 7'h00, 16'h0070, 4'd8},
        '{1'b1, 7'h00, 16'h0000, 4'd8},
        '{1'b0, 7'h00, 16'h00FF, 4'd3},
        '{1'b0, 7'h11, 16'h0010, 4'd3},   // R3 alternate program code
        '{1'b0, 7'h11, 16'hABCD, 4'd3},
        '{1'b0, 7'h12, 16'h0040, 4'd3},
        '{1'b0, 7'h12, 16'h5555, 4'd3},
        '{1'b1, 7'h11, 16'hABCD, 4'd3},
        '{1'b0, 7'h10, 16'h0020, 4'd5},   // R5 erase sector 1
        '{1'b1, 7'h11, 16'h0080, 4'd7},
        '{1'b0, 7'h10, 16'h00D0, 4'd5},
        '{1'b1, 7'h11, 16'h0080, 4'd7},
        '{1'b0, 7'h00, 16'h00FF, 4'd5},
        '{1'b1, 7'h11, 16'hFFFF, 4'd5},
        '{1'b1, 7'h12, 16'hFFFF, 4'd5},
        '{1'b1, 7'h02, 16'h1234, 4'd5},   // R5 other sector kept
        '{1'b0, 7'h02, 16'h0020, 4'd6},   // R6 erase abort
        '{1'b0, 7'h02, 16'h00FF, 4'd6},
        '{1'b1, 7'h02, 16'h1234, 4'd6},
        '{1'b0, 7'h00, 16'h0090, 4'd9},   // R9 identifier
        '{1'b1, 7'h00, MFR,      4'd9},
        '{1'b1, 7'h01, DEV,      4'd9},
        '{1'b1, 7'h02, 16'h0000, 4'd9},
        '{1'b0, 7'h00, 16'h0098, 4'd10},  // R10 query
        '{1'b1, 7'h10, 16'h0051, 4'd10},
        '{1'b1, 7'h2D, 16'h0003, 4'd10},
        '{1'b1, 7'h7F, 16'h0000, 4'd10},
        '{1'b0, 7'h00, 16'h0070, 4'd10},
        '{1'b1, 7'h11, 16'h0052, 4'd10},
        '{1'b0, 7'h00, 16'h00FF, 4'd10},
        '{1'b1, 7'h02, 16'h1234, 4'd10},
        '{1'b0, 7'h20, 16'h00E8, 4'd11},  // R11 buffered write, 3 words
        '{1'b0, 7'h20, 16'h0002, 4'd11},
        '{1'b0, 7'h20, 16'h1111, 4'd11},
        '{1'b0, 7'h21, 16'h2222, 4'd11},
        '{1'b0, 7'h22, 16'h3333, 4'd11},
        '{1'b1, 7'h20, 16'h0080, 4'd7},
        '{1'b0, 7'h20, 16'h00D0, 4'd11},
        '{1'b0, 7'h00, 16'h00FF, 4'd11},
        '{1'b1, 7'h20, 16'h1111, 4'd11},
        '{1'b1, 7'h21, 16'h2222, 4'd11},
        '{1'b1, 7'h22, 16'h3333, 4'd11},
        '{1'b1, 7'h23, 16'hFFFF, 4'd11},
        '{1'b0, 7'h00, 16'h0070, 4'd12},  // R12 unknown code
        '{1'b0, 7'h00, 16'h0033, 4'd12},
        '{1'b1, 7'h02, 16'h1234, 4'd12},
        '{1'b0, 7'h00, 16'h0060, 4'd13},  // R13 lock
        '{1'b0, 7'h00, 16'h0001, 4'd13},
        '{1'b1, 7'h00, 16'h0080, 4'd13},
        '{1'b0, 7'h00, 16'h0060, 4'd13},
        '{1'b0, 7'h00, 16'h0077, 4'd13},
        '{1'b1, 7'h02, 16'h1234, 4'd13}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        ro_strap = 1'b0;
    logic [15:0] rd_data;
    logic        rdy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pnor_cmd_engine #(.ID_MFR(MFR), .ID_DEV(DEV)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ro_strap(ro_strap), .rd_data(rd_data), .rdy(rdy)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic is_rd, input logic [6:0] a,
                          input logic [15:0] d, input string req);
        @(negedge clk);
        addr = a;
        if (is_rd) rd_en = 1'b1;
        else begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        check("R2 rdy high", {15'd0, rdy}, 16'd1);
        if (is_rd) check(req, rd_data, d);
        @(negedge clk);
        check("R2 rdy low", {15'd0, rdy}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdy after reset", {15'd0, rdy}, 16'd0);
        access(1'b0, 7'h00, 16'h0070, "R1");
        access(1'b1, 7'h00, 16'h0000, "R1 status zero");
        access(1'b0, 7'h00, 16'h00FF, "R1");

        for (int i = 0; i < NV; i++)
            access(VECS[i].is_rd, VECS[i].a, VECS[i].d,
                   $sformatf("R%0d vec %0d", VECS[i].req, i));

        // R4: read-only program leaves word and flags 0x10
        access(1'b0, 7'h00, 16'h0050, "R4");
        ro_strap = 1'b1;
        access(1'b0, 7'h02, 16'h0040, "R4");
        access(1'b0, 7'h02, 16'h9999, "R4");
        access(1'b0, 7'h00, 16'h0070, "R4");
        access(1'b1, 7'h00, 16'h0090, "R4 status");
        access(1'b0, 7'h00, 16'h00FF, "R4");
        access(1'b1, 7'h02, 16'h1234, "R4 array kept");
        // R5: read-only erase leaves sector and flags 0x20
        access(1'b0, 7'h00, 16'h0050, "R5");
        access(1'b0, 7'h02, 16'h0020, "R5");
        access(1'b0, 7'h02, 16'h00D0, "R5");
        access(1'b1, 7'h00, 16'h00A0, "R5 ro status");
        access(1'b0, 7'h00, 16'h00FF, "R5");
        access(1'b1, 7'h02, 16'h1234, "R5 ro array kept");
        ro_strap = 1'b0;
        // R1: reset mid-run restores blank array and idle state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b1, 7'h02, 16'hFFFF, "R1 array after reset");
        access(1'b1, 7'h20, 16'hFFFF, "R1 array after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule